// File: doc/BRIEF.md
# Digit-Serial GHASH Authentication Hash

This block computes the Galois-field authentication hash used by GCM over a stream of 128-bit blocks. The hash subkey arrives on its own port, already derived by the surrounding cipher logic. Data words arrive over a valid/ready handshake, and each word is tagged as additional authenticated data, as ciphertext, or as the request to finish. Each accepted word is XORed into the running chain value, and the sum is multiplied by the subkey in GF(2^128). A final partial word is zero-padded on the right. The block counts the bits of both streams itself. On the finish request it absorbs the length block and then presents the result as the tag, along with a one-cycle done strobe.

The field product is built digit by digit. One digit of the subkey (16 bits by default) is applied per clock through a 128-by-16 partial-product array. The running accumulator is multiplied by x^16 and reduced at each digit step, so a full product takes eight cycles. A synchronous clear returns the chain value and both length counters to zero so that a new message can begin. The subkey must stay constant for the whole of a message.

Top module: `ghash_mac`

## Requirements
- R1: After reset, in_ready is 1, done_o is 0 and tag_o is all zeros.
- R2: Each accepted word updates the chain X to (X xor W)·H in GF(2^128), where W is the padded word and H is hkey. The product uses the reflected GCM convention: bit 127 of a vector is the coefficient of x^0, and bit 0 is the coefficient of x^127. It is reduced by x^128 + x^7 + x^2 + x + 1. The chain value is zero after reset and after clear.
- R3: After the clock edge that accepts a word, in_ready is 0 for exactly 128/DIGIT_W cycles (8 by default) and then returns to 1. The updated chain value is on tag_o from the cycle in_ready returns.
- R4: in_kind encodes the word type: 2'b00 is additional data, 2'b01 is ciphertext, and 2'b10 or 2'b11 is the finish request.
- R5: On a data word, in_nbytes gives the count of valid bytes, 1 to 16. Byte 0 is bits 127:120. Bytes at positions greater than or equal to the count are replaced by zero before absorption. A value of 0 or above 16 means all 16 bytes are valid.
- R6: The block keeps two 64-bit bit counts: one for additional data and one for ciphertext. Each accepted data word adds 8·(valid bytes) to the count of its type. A finish request absorbs the word {additional-data bit count, ciphertext bit count}, with the additional-data count in bits 127:64. in_data and in_nbytes have no effect on a finish request.
- R7: done_o pulses for exactly one cycle, in the cycle in_ready returns after a finish request. At that point tag_o holds the final chain value. done_o never rises after a data word.
- R8: While in_ready is 1 and no word is accepted, tag_o does not change.
- R9: clear is synchronous and takes priority over everything else. It abandons any product in progress and zeroes the chain and both bit counts. In the next cycle in_ready is 1, done_o is 0 and tag_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous restart of the hash chain and counts |
| hkey | input | 128 | Hash subkey H, held constant for a message |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can accept a word |
| in_kind | input | 2 | Word type: 00 additional data, 01 ciphertext, 1x finish |
| in_nbytes | input | 5 | Valid byte count of a data word |
| in_data | input | 128 | Input word, byte 0 in bits 127:120 |
| tag_o | output | 128 | Current chain value; the tag after a finish |
| done_o | output | 1 | One-cycle strobe: tag_o holds the final tag |

## Verification
Every result of this block is due a fixed eight clocks after the edge that accepts a word. On that edge in_ready rises, the new chain value appears, and done_o pulses if the word was a finish request. Clear acts on the very next edge. The bench drives inputs and samples outputs on falling edges. For every word, it counts the falling edges during which in_ready stays low and expects exactly eight. The scoreboard monitor pops an expected tag at the falling edge where done_o is seen, and compares it against a bit-serial reference multiplier and against hand-derivable values: an all-empty message, and a unit subkey.

// File: rtl/ghash_pkg.sv
package ghash_pkg;

   localparam int BLK_W  = 128;
   localparam int BYTE_N = BLK_W / 8;

   typedef logic [BLK_W-1:0] blk_t;

   // word type on in_kind; bit 1 set means finish
   typedef enum logic [1:0] {
      KIND_AAD  = 2'b00,
      KIND_CT   = 2'b01,
      KIND_FIN  = 2'b10,
      KIND_FINX = 2'b11
   } kind_e;

   // x^128 = x^7 + x^2 + x + 1, reflected: coefficients x^0,x^1,x^2,x^7 in the top byte
   localparam blk_t RED_POLY = {8'hE1, 120'd0};

   // multiply by x in the reflected representation
   function automatic blk_t gf_mulx(input blk_t v);
      gf_mulx = {1'b0, v[BLK_W-1:1]} ^ (v[0] ? RED_POLY : '0);
   endfunction

endpackage

// File: rtl/ghash_digit_array.sv
module ghash_digit_array
   import ghash_pkg::*;
#(
   parameter int DIGIT_W = 16
) (
   input  blk_t               a_i,
   input  blk_t               z_i,
   input  logic [DIGIT_W-1:0] digit_i,
   output blk_t               z_o
);

   // a_i * x^k for k = 0 .. DIGIT_W-1
   blk_t ashift [DIGIT_W];
   // z_i * x^k for k = 0 .. DIGIT_W
   blk_t zshift [DIGIT_W+1];
   // running partial-product sum
   blk_t psum   [DIGIT_W+1];

   assign ashift[0] = a_i;
   assign zshift[0] = z_i;
   assign psum[0]   = '0;

   generate
      for (genvar k = 1; k < DIGIT_W; k++) begin : g_ash
         assign ashift[k] = gf_mulx(ashift[k-1]);
      end
      for (genvar k = 0; k < DIGIT_W; k++) begin : g_row
         assign zshift[k+1] = gf_mulx(zshift[k]);
         // digit bit DIGIT_W-1-k carries the coefficient of x^k within the digit
         assign psum[k+1]   = psum[k] ^ (digit_i[DIGIT_W-1-k] ? ashift[k] : '0);
      end
   endgenerate

   // Horner step: Z*x^DIGIT_W + A*digit
   assign z_o = zshift[DIGIT_W] ^ psum[DIGIT_W];

endmodule

// File: rtl/ghash_pad.sv
module ghash_pad
   import ghash_pkg::*;
#(
   parameter int LEN_W = 64
) (
   input  blk_t             data_i,
   input  logic [4:0]       nbytes_i,
   input  logic             fin_i,
   input  logic [LEN_W-1:0] len_a_i,
   input  logic [LEN_W-1:0] len_c_i,
   output blk_t             word_o,
   output logic [7:0]       bits_o
);

   logic [4:0] nb_eff;
   blk_t       masked;

   assign nb_eff = (nbytes_i == 5'd0 || nbytes_i > 5'(BYTE_N)) ? 5'(BYTE_N) : nbytes_i;
   assign bits_o = {nb_eff, 3'b000};

   generate
      for (genvar b = 0; b < BYTE_N; b++) begin : g_byte
         assign masked[BLK_W-1-8*b -: 8] =
            (nb_eff > 5'(b)) ? data_i[BLK_W-1-8*b -: 8] : 8'h00;
      end
   endgenerate

   assign word_o = fin_i ? {len_a_i, len_c_i} : masked;

endmodule

// File: rtl/ghash_ctrl.sv
module ghash_ctrl #(
   parameter int STEPS = 8,
   localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             accept_i,
   input  logic             fin_i,
   output logic             busy_o,
   output logic [CNT_W-1:0] step_o,
   output logic             last_o,
   output logic             done_o
);

   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;
   logic             fin_q;
   logic             done_q;

   assign busy_o = busy_q;
   assign step_o = cnt_q;
   assign last_o = busy_q && (cnt_q == CNT_W'(STEPS-1));
   assign done_o = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         fin_q  <= 1'b0;
         done_q <= 1'b0;
      end else if (clear) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         fin_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept_i) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            fin_q  <= fin_i;
         end else if (busy_q) begin
            if (cnt_q == CNT_W'(STEPS-1)) begin
               busy_q <= 1'b0;
               done_q <= fin_q;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/ghash_mac.sv
module ghash_mac
   import ghash_pkg::*;
#(
   parameter int DIGIT_W = 16,
   parameter int LEN_W   = 64,
   localparam int STEPS  = BLK_W / DIGIT_W,
   localparam int CNT_W  = (STEPS > 1) ? $clog2(STEPS) : 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic [127:0] hkey,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [1:0]   in_kind,
   input  logic [4:0]   in_nbytes,
   input  logic [127:0] in_data,
   output logic [127:0] tag_o,
   output logic         done_o
);

   generate
      if (BLK_W % DIGIT_W != 0 || STEPS < 2) begin : g_bad_digit
         $error("ghash_mac: DIGIT_W must divide 128 into at least two digits");
      end
      if (2 * LEN_W != BLK_W) begin : g_bad_len
         $error("ghash_mac: LEN_W must be half the block width");
      end
   endgenerate

   logic             busy;
   logic             last;
   logic [CNT_W-1:0] step;
   logic             accept;
   logic             fin;
   blk_t             word;
   logic [7:0]       add_bits;
   blk_t             z_next;

   blk_t             x_q;
   blk_t             a_q;
   blk_t             z_q;
   logic [LEN_W-1:0] len_a_q;
   logic [LEN_W-1:0] len_c_q;

   logic [DIGIT_W-1:0] hdig [STEPS];

   generate
      for (genvar s = 0; s < STEPS; s++) begin : g_hdig
         assign hdig[s] = hkey[s*DIGIT_W +: DIGIT_W];
      end
   endgenerate

   assign in_ready = ~busy;
   assign accept   = in_valid & ~busy & ~clear;
   assign fin      = in_kind[1];

   ghash_ctrl #(.STEPS(STEPS)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (clear),
      .accept_i (accept),
      .fin_i    (fin),
      .busy_o   (busy),
      .step_o   (step),
      .last_o   (last),
      .done_o   (done_o)
   );

   ghash_pad #(.LEN_W(LEN_W)) u_pad (
      .data_i   (in_data),
      .nbytes_i (in_nbytes),
      .fin_i    (fin),
      .len_a_i  (len_a_q),
      .len_c_i  (len_c_q),
      .word_o   (word),
      .bits_o   (add_bits)
   );

   ghash_digit_array #(.DIGIT_W(DIGIT_W)) u_arr (
      .a_i     (a_q),
      .z_i     (z_q),
      .digit_i (hdig[step]),
      .z_o     (z_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_q     <= '0;
         a_q     <= '0;
         z_q     <= '0;
         len_a_q <= '0;
         len_c_q <= '0;
      end else if (clear) begin
         x_q     <= '0;
         a_q     <= '0;
         z_q     <= '0;
         len_a_q <= '0;
         len_c_q <= '0;
      end else if (accept) begin
         a_q <= x_q ^ word;
         z_q <= '0;
         if (!fin) begin
            if (in_kind[0]) len_c_q <= len_c_q + LEN_W'(add_bits);
            else            len_a_q <= len_a_q + LEN_W'(add_bits);
         end
      end else if (busy) begin
         z_q <= z_next;
         if (last) x_q <= z_next;
      end
   end

   assign tag_o = x_q;

endmodule

// File: rtl/ghash_mac_chk.sv
module ghash_mac_chk #(
   parameter int STEPS = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         clear,
   input logic         in_valid,
   input logic         in_ready,
   input logic [127:0] tag_o,
   input logic         done_o
);

   int unsigned low_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         low_run <= 0;
      else if (in_ready)  low_run <= 0;
      else                low_run <= low_run + 1;
   end

   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !clear) |=> !in_ready); // R3

   AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      low_run <= STEPS); // R3

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R7

   AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> in_ready); // R7

   AST_TAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && !in_valid && !clear) |=> $stable(tag_o)); // R8

   AST_CLEAR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (in_ready && !done_o && tag_o == '0)); // R9

endmodule

bind ghash_mac ghash_mac_chk #(.STEPS(128 / DIGIT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .clear    (clear),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .tag_o    (tag_o),
   .done_o   (done_o)
);

// File: tb/ghash_mac_test.sv
module ghash_mac_test;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         clear = 1'b0;
   logic [127:0] hkey = '0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [1:0]   in_kind = 2'b00;
   logic [4:0]   in_nbytes = 5'd16;
   logic [127:0] in_data = '0;
   logic [127:0] tag_o;
   logic         done_o;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   logic [127:0] exp_q [$];
   logic [127:0] mx;
   logic [63:0]  mla, mlc;

   always #2 clk = ~clk;   // 250 MHz

   ghash_mac uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (clear),
      .hkey      (hkey),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_kind   (in_kind),
      .in_nbytes (in_nbytes),
      .in_data   (in_data),
      .tag_o     (tag_o),
      .done_o    (done_o)
   );

   task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // bit-serial reference product, reflected convention
   function automatic logic [127:0] ref_mul(input logic [127:0] x, input logic [127:0] y);
      logic [127:0] z = '0;
      logic [127:0] v = x;
      for (int i = 0; i < 128; i++) begin
         if (y[127-i]) z ^= v;
         v = v[0] ? ((v >> 1) ^ {8'hE1, 120'd0}) : (v >> 1);
      end
      return z;
   endfunction

   function automatic int eff_bytes(input logic [4:0] nb);
      return (nb == 0 || nb > 16) ? 16 : int'(nb);
   endfunction

   function automatic logic [127:0] ref_pad(input logic [127:0] d, input logic [4:0] nb);
      logic [127:0] r = d;
      for (int b = eff_bytes(nb); b < 16; b++) r[127-8*b -: 8] = 8'h00;
      return r;
   endfunction

   // driver: models the word, pushes expected tags, and times the busy window
   task automatic send(input logic [1:0] kind, input logic [127:0] data, input logic [4:0] nb);
      int lowcnt;
      if (kind[1]) begin
         mx = ref_mul(mx ^ {mla, mlc}, hkey);   // R6
         exp_q.push_back(mx);
      end else begin
         mx = ref_mul(mx ^ ref_pad(data, nb), hkey);   // R2 R5
         if (kind[0]) mlc += 64'(8 * eff_bytes(nb));
         else         mla += 64'(8 * eff_bytes(nb));
      end
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid  = 1'b1;
      in_kind   = kind;
      in_data   = data;
      in_nbytes = nb;
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = '0;
      lowcnt = 0;
      while (!in_ready && lowcnt < 40) begin
         lowcnt++;
         @(negedge clk);
      end
      check(lowcnt == 8, "R3 busy cycles", 128'(lowcnt), 128'd8);
      if (!kind[1]) check(tag_o == mx, "R2 chain value", tag_o, mx);
   endtask

   task automatic do_clear();
      @(negedge clk);
      clear = 1'b1;
      @(negedge clk);
      clear = 1'b0;
      mx = '0; mla = '0; mlc = '0;
      check(in_ready == 1'b1 && done_o == 1'b0, "R9 ready after clear", 128'({in_ready, done_o}), 128'b10);
      check(tag_o == '0, "R9 tag cleared", tag_o, '0);
   endtask

   // monitor: scoreboard comparison on every done strobe
   always @(negedge clk) begin
      if (rst_n && done_o) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R7 unexpected done", tag_o, '0);
         end else begin
            logic [127:0] e;
            e = exp_q.pop_front();
            check(tag_o == e, "R7 final tag", tag_o, e);
         end
      end
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin : stim
      logic [127:0] held;
      mx = '0; mla = '0; mlc = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(in_ready == 1'b1, "R1 ready at reset", 128'(in_ready), 128'd1);
      check(done_o == 1'b0, "R1 done at reset", 128'(done_o), 128'd0);
      check(tag_o == '0, "R1 tag at reset", tag_o, '0);
      rst_n = 1'b1;

      // R6: empty message gives an all-zero tag
      hkey = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e;
      do_clear();
      send(2'b10, 128'h0, 5'd16);
      check(tag_o == '0, "R6 empty message tag", tag_o, '0);
      // R7: strobe is gone next cycle
      @(negedge clk);
      check(done_o == 1'b0, "R7 done one cycle", 128'(done_o), '0);

      // R2: unit subkey, tag = word xor {128 bits of AAD, 0}
      hkey = {1'b1, 127'd0};
      do_clear();
      send(2'b00, 128'h0123456789abcdeffedcba9876543210, 5'd16);
      send(2'b10, 128'h0, 5'd16);
      check(tag_o == (128'h0123456789abcdeffedcba9876543210 ^ {64'd128, 64'd0}),
            "R2 unit subkey tag", tag_o,
            128'h0123456789abcdeffedcba9876543210 ^ {64'd128, 64'd0});

      // R2 R4: known subkey, one ciphertext block
      hkey = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e;
      do_clear();
      send(2'b01, 128'h0388dace60b6a392f328c2b971b2fe78, 5'd16);
      send(2'b10, 128'h0, 5'd16);

      // R4 R5 R6: AAD and ciphertext with partial tails holding garbage
      hkey = 128'hb83b533708bf535d0aa6e52980d53b78;
      do_clear();
      send(2'b00, 128'hfeedfacedeadbeeffeedfacedeadbeef, 5'd16);
      send(2'b00, 128'habaddad2ffffffffffffffffffffffff, 5'd4);
      send(2'b01, 128'h42831ec2217774244b7221b784d0d49c, 5'd0);
      send(2'b01, 128'he3aa212f2c02a4e035c17e2329aca12e, 5'd16);
      send(2'b01, 128'h1ba30b396a0aac973d58e091aaaaaaaa, 5'd12);
      send(2'b01, 128'h5555555555555555555555555555555a, 5'd31);
      send(2'b10, 128'h0, 5'd16);

      // R6: finish word data and count are ignored; 2'b11 also finishes (R4)
      do_clear();
      send(2'b00, 128'h00112233445566778899aabbccddeeff, 5'd7);
      send(2'b11, 128'hffffffffffffffffffffffffffffffff, 5'd3);

      // R8: tag holds while idle
      held = tag_o;
      repeat (6) @(negedge clk);
      check(tag_o == held, "R8 tag stable while idle", tag_o, held);

      // R9: clear during a product abandons it
      @(negedge clk);
      in_valid = 1'b1; in_kind = 2'b00; in_data = 128'h1; in_nbytes = 5'd16;
      @(negedge clk);
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      check(in_ready == 1'b0, "R3 busy mid product", 128'(in_ready), '0);
      do_clear();
      send(2'b01, 128'hcafebabe0000000011111111deadc0de, 5'd16);
      send(2'b10, 128'h0, 5'd16);

      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R7 all tags delivered", 128'(exp_q.size()), '0);
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule